// File: doc/BRIEF.md
# SPI Register Read Responder with Running CRC-16

This block is an SPI target that answers register read requests. A host lowers chip select and clocks in a 16-bit command word. The command carries a register address and a read flag. The block then returns the addressed register on MISO, most significant bit first. A register below a configurable boundary address is a 16-bit register and returns two bytes. A register at or above the boundary is a 32-bit register and returns four bytes. Straight after the last data bit, the block sends a 16-bit CRC-16-CCITT. This CRC is one running value over every returned data bit of the frame.

The block runs entirely in the system clock domain. SCLK, chip select and MOSI pass through synchronisers, and SCLK edges are detected from the synchronised copy. Register values come from a parallel read port (`rd_addr` out, `rd_data` in) that suits a block RAM with a registered output. Raising chip select at any point abandons the frame, so the next frame starts from a clean state.

Top module: `spi_regread_crc`

## Requirements
- R1: After reset, `spi_miso` is 0 and `rd_addr` is 0.
- R2: The command is 16 bits, sampled MSB first on rising SCLK edges. Bits [15:4] are the address and bit 3 is the read flag (1 = read); bits [2:0] are ignored. For a read, `rd_addr` takes the address after the 16th rising edge.
- R3: An address below `WIDE_BASE` (default 0x400) selects a 16-bit register. The block returns bits [15:0] of `rd_data` as 16 MISO bits, MSB first.
- R4: An address at or above `WIDE_BASE` selects a 32-bit register. The block returns all 32 bits of `rd_data` as 32 MISO bits, MSB first.
- R5: The 16 CRC bits follow the last data bit with no gap, MSB first. Afterwards MISO is 0 until chip select rises.
- R6: The CRC uses polynomial 0x1021 and is preset to 0xFFFF for every frame. Data bits are fed in MSB first in transmit order, with no final XOR. A single value covers all 2 or 4 data bytes.
- R7: The design uses SPI mode 0. MISO only changes after a falling SCLK edge, and it is 0 for the whole command phase.
- R8: A command with bit 3 = 0 produces no response: MISO stays 0 for the rest of the frame and `rd_addr` keeps its previous value.
- R9: MOSI levels during the data and CRC phases have no effect on the returned data or CRC.
- R10: Raising chip select at any point aborts the frame. The bit count, phase and CRC restart, so the next frame is decoded and answered correctly. `rd_addr` keeps its value.
- R11: `rd_data` is sampled on the second clock edge after `rd_addr` updates. SCLK high and low times must each be at least 4 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, registered |
| rd_addr | output | ADDR_W | Register address presented to the read port |
| rd_data | input | DATA_W | Register value returned by the read port |

## Verification
Each SPI pin change reaches the core three clock edges later, after two synchroniser stages and the edge detector. A MISO bit therefore settles about four clock cycles after the falling SCLK edge that launches it, and `rd_addr` settles the same distance after the 16th rising edge. The bench holds every SCLK level for six clock cycles and samples MISO just before each SCLK transition, at a falling clock edge. By then every result is due and none is yet superseded. A model in the bench answers read-port requests after one registered cycle, so data arrives exactly when R11 says it is sampled. Comparing MISO just before the rise with its value just before the following fall shows that no bit moves while SCLK is high.

// File: rtl/spirr_pkg.sv
package spirr_pkg;
  typedef enum logic [2:0] {
    PH_CMD    = 3'd0,
    PH_FETCH1 = 3'd1,
    PH_FETCH2 = 3'd2,
    PH_DATA   = 3'd3,
    PH_CRC    = 3'd4,
    PH_TAIL   = 3'd5
  } phase_t;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
  localparam int READ_FLAG_BIT = 3;
  localparam int CMD_TAG_W = 4;
endpackage

// File: rtl/spirr_sync.sv
module spirr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_out,
  output logic cs_active
);
  logic [STAGES-1:0] sclk_p;
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] mosi_p;
  logic              sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk_in};
      cs_p   <= {cs_p[STAGES-2:0], cs_n_in};
      mosi_p <= {mosi_p[STAGES-2:0], mosi_in};
      sclk_d <= sclk_p[STAGES-1];
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
  assign mosi_out  = mosi_p[STAGES-1];
  assign cs_active = ~cs_p[STAGES-1];
endmodule

// File: rtl/spirr_crc16.sv
module spirr_crc16 #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc
);
  logic fb;
  assign fb = crc[15] ^ din;

  always_ff @(posedge clk) begin
    if (rst || clr)
      crc <= INIT;
    else if (en)
      crc <= {crc[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
  end

  // R6: every frame starts from the preset value
  assert_crc_preset_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc == INIT));

  // R6: the running value only moves when a data bit is shifted out
  assert_crc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/spi_regread_crc.sv
module spi_regread_crc #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] WIDE_BASE = 'h400,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  import spirr_pkg::*;

  localparam int CMD_W     = ADDR_W + CMD_TAG_W;
  localparam int HALF_W    = DATA_W / 2;
  localparam int CNT_W     = $clog2(DATA_W + 1);
  localparam int CMD_CNT_W = $clog2(CMD_W + 1);

  logic sclk_rise, sclk_fall, mosi_s, cs_act;

  spirr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk_in   (spi_sclk),
    .cs_n_in   (spi_cs_n),
    .mosi_in   (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_out  (mosi_s),
    .cs_active (cs_act)
  );

  phase_t               phase;
  logic [CMD_W-2:0]     cmd_sr;
  logic [CMD_CNT_W-1:0] cmd_cnt;
  logic [DATA_W-1:0]    data_sr;
  logic [CNT_W-1:0]     bits_left;
  logic                 wide_q;
  logic [CRC_W-1:0]     crc_sr;
  logic                 miso_q;
  logic [ADDR_W-1:0]    addr_q;

  logic [CMD_W-1:0]  cmd_next;
  logic [ADDR_W-1:0] cmd_addr;
  logic              cmd_done;
  logic              unused_cmd_bits;

  assign cmd_next        = {cmd_sr, mosi_s};
  assign cmd_addr        = cmd_next[CMD_W-1:CMD_TAG_W];
  assign cmd_done        = cs_act && (phase == PH_CMD) && sclk_rise &&
                           (cmd_cnt == CMD_CNT_W'(CMD_W - 1));
  assign unused_cmd_bits = ^cmd_next[READ_FLAG_BIT-1:0];

  logic             crc_clr, crc_en;
  logic [CRC_W-1:0] crc_val;

  assign crc_clr = !cs_act || (phase == PH_FETCH1);
  assign crc_en  = cs_act && (phase == PH_DATA) && sclk_fall;

  spirr_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (crc_clr),
    .en  (crc_en),
    .din (data_sr[DATA_W-1]),
    .crc (crc_val)
  );

  // address register: survives an aborted frame
  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (cmd_done && cmd_next[READ_FLAG_BIT])
      addr_q <= cmd_addr;
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      phase     <= PH_CMD;
      cmd_sr    <= '0;
      cmd_cnt   <= '0;
      data_sr   <= '0;
      bits_left <= '0;
      wide_q    <= 1'b0;
      crc_sr    <= '0;
      miso_q    <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: begin
          if (sclk_rise) begin
            cmd_sr  <= cmd_next[CMD_W-2:0];
            cmd_cnt <= cmd_cnt + 1'b1;
            if (cmd_cnt == CMD_CNT_W'(CMD_W - 1)) begin
              if (cmd_next[READ_FLAG_BIT]) begin
                wide_q <= (cmd_addr >= WIDE_BASE);
                phase  <= PH_FETCH1;
              end else begin
                phase  <= PH_TAIL;
              end
            end
          end
        end
        PH_FETCH1: phase <= PH_FETCH2;
        PH_FETCH2: begin
          data_sr   <= wide_q ? rd_data : {rd_data[HALF_W-1:0], {HALF_W{1'b0}}};
          bits_left <= wide_q ? CNT_W'(DATA_W) : CNT_W'(HALF_W);
          phase     <= PH_DATA;
        end
        PH_DATA: begin
          if (sclk_fall) begin
            miso_q  <= data_sr[DATA_W-1];
            data_sr <= {data_sr[DATA_W-2:0], 1'b0};
            if (bits_left == CNT_W'(1)) begin
              bits_left <= CNT_W'(CRC_W);
              phase     <= PH_CRC;
            end else begin
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        PH_CRC: begin
          if (sclk_fall) begin
            if (bits_left == CNT_W'(CRC_W)) begin
              miso_q <= crc_val[CRC_W-1];
              crc_sr <= {crc_val[CRC_W-2:0], 1'b0};
            end else begin
              miso_q <= crc_sr[CRC_W-1];
              crc_sr <= {crc_sr[CRC_W-2:0], 1'b0};
            end
            bits_left <= bits_left - 1'b1;
            if (bits_left == CNT_W'(1))
              phase <= PH_TAIL;
          end
        end
        default: begin
          if (sclk_fall)
            miso_q <= 1'b0;
        end
      endcase
    end
  end

  assign spi_miso = miso_q;
  assign rd_addr  = addr_q;

  // R7: MISO moves only on a detected falling SCLK edge while selected
  assert_miso_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !sclk_fall) |=> $stable(spi_miso));

  // R7: nothing is driven during the command phase
  assert_cmd_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CMD) |-> !spi_miso);

  // R10: deselect returns the frame to its start
  assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!spi_miso && phase == PH_CMD));

  // R11: the read port address is held while its data is used
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH2 || phase == PH_DATA || phase == PH_CRC) |=> $stable(rd_addr));

  // R4: the bit counter never exceeds the widest register
  assert_bits_range_R4: assert property (@(posedge clk) disable iff (rst)
    bits_left <= CNT_W'(DATA_W));
endmodule

// File: tb/spi_regread_crc_tb_top.sv
module spi_regread_crc_tb_top;
  localparam int HALF = 6;
  localparam logic [11:0] WIDE_BASE = 12'h400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [11:0] rd_addr;
  logic [31:0] rd_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [127:0] rx;
  int unstable;

  always #2 clk = ~clk;

  spi_regread_crc dut_i (
    .clk      (clk),
    .rst      (rst),
    .spi_sclk (sclk),
    .spi_cs_n (cs_n),
    .spi_mosi (mosi),
    .spi_miso (miso),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  function automatic logic [31:0] regval(input logic [11:0] a);
    return ({20'h0, a} * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  // read port with one registered cycle, like a block RAM
  always @(posedge clk) rd_data <= regval(rd_addr);

  function automatic logic [15:0] crc_ref(input logic [31:0] d, input int nbits);
    logic [15:0] c;
    logic b;
    c = 16'hFFFF;
    for (int i = nbits - 1; i >= 0; i--) begin
      b = d[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (b) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] cmd, input int nbits, input logic fill, input int abort_at);
    logic b0;
    rx = '0;
    unstable = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (abort_at >= 0 && i == abort_at) break;
      mosi = (i < 16) ? cmd[15-i] : (fill ^ i[0]);
      repeat (HALF) @(negedge clk);
      b0 = miso;
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (miso !== b0) unstable++;
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic check_read(input logic [11:0] a, input logic fill);
    logic        wide;
    int          nd;
    logic [31:0] full, exp_d, got_d;
    logic [15:0] exp_c, got_c;
    logic [15:0] cmdz;
    logic [3:0]  tail;
    wide  = (a >= WIDE_BASE);
    nd    = wide ? 32 : 16;
    full  = regval(a);
    exp_d = wide ? full : {16'h0, full[15:0]};
    exp_c = crc_ref(exp_d, nd);
    frame({a, 4'b1000}, 16 + nd + 16 + 4, fill, -1);
    got_d = '0;
    got_c = '0;
    for (int i = 0; i < 16; i++) cmdz[15-i] = rx[i];
    for (int i = 0; i < nd; i++) got_d[nd-1-i] = rx[16+i];
    for (int i = 0; i < 16; i++) got_c[15-i] = rx[16+nd+i];
    for (int i = 0; i < 4; i++) tail[3-i] = rx[32+nd+i];
    chk(cmdz == 16'h0, "R7 MISO low in command phase", {16'h0, cmdz}, 32'h0);
    chk(rd_addr == a, "R2 command address", {20'h0, rd_addr}, {20'h0, a});
    if (wide) chk(got_d == exp_d, "R4 R9 R11 32-bit data", got_d, exp_d);
    else      chk(got_d == exp_d, "R3 R9 R11 16-bit data", got_d, exp_d);
    chk(got_c == exp_c, "R5 R6 CRC", {16'h0, got_c}, {16'h0, exp_c});
    chk(tail == 4'h0, "R5 MISO low after CRC", {28'h0, tail}, 32'h0);
    chk(unstable == 0, "R7 MISO stable while SCLK high", unstable, 32'h0);
  endtask

  initial begin
    repeat (200000 - 500) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] prev;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(miso == 1'b0, "R1 reset MISO", {31'h0, miso}, 32'h0);
    chk(rd_addr == 12'h0, "R1 reset rd_addr", {20'h0, rd_addr}, 32'h0);

    // R3: sweep of 16-bit registers, MOSI fill alternates for R9
    for (int i = 0; i < 16; i++)
      check_read((i == 15) ? 12'h3FF : 12'(i * 67), i[0]);
    // R4: sweep of 32-bit registers including both boundary addresses
    for (int i = 0; i < 16; i++)
      check_read((i == 15) ? 12'hFFF : 12'(WIDE_BASE + 12'(i * 197)), i[0]);
    // R9: same register with opposite MOSI fill
    check_read(12'h123, 1'b0);
    check_read(12'h123, 1'b1);
    check_read(12'h9AB, 1'b0);
    check_read(12'h9AB, 1'b1);

    // R8: read flag clear gives no response
    prev = rd_addr;
    frame({12'h055, 4'b0000}, 68, 1'b1, -1);
    chk(rx[67:0] == 68'h0, "R8 no response MISO", rx[31:0], 32'h0);
    chk(rd_addr == prev, "R8 rd_addr kept", {20'h0, rd_addr}, {20'h0, prev});
    frame({12'hA5A, 4'b0111}, 68, 1'b0, -1);
    chk(rx[67:0] == 68'h0, "R8 no response other tag bits", rx[31:0], 32'h0);
    chk(rd_addr == prev, "R8 rd_addr kept again", {20'h0, rd_addr}, {20'h0, prev});

    // R10: abort in command, data and CRC phases, then a clean frame
    prev = rd_addr;
    frame({12'h7E1, 4'b1000}, 68, 1'b0, 9);
    chk(rd_addr == prev, "R10 rd_addr kept after command abort", {20'h0, rd_addr}, {20'h0, prev});
    check_read(12'hC3C, 1'b1);
    frame({12'h800, 4'b1000}, 68, 1'b0, 30);
    check_read(12'h0A5, 1'b0);
    frame({12'h0F0, 4'b1000}, 52, 1'b1, 40);
    check_read(12'hE17, 1'b1);
    frame({12'h300, 4'b1000}, 52, 1'b0, 17);
    check_read(12'h300, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule